// File: doc/BRIEF.md
# Seven-to-One Pixel Serializer

This block turns one 21-bit pixel word per pixel-clock period into three serial data lanes and one framing lane. Each lane carries seven bit slots per pixel period. The pixel word holds 18 colour bits (six each of red, green and blue) and three timing bits (line sync, frame sync and data enable). The whole block runs on one bit clock at seven times the pixel rate. The pixel clock comes from the same source. The block samples the pixel clock as a level and uses its rising edges to keep the slot counter in step.

A static strap input chooses the pixel-clock edge on which the input word is taken: the rising edge when the strap is high, the falling edge when it is low. The captured word waits in a shadow register. It moves into the lane shift registers only at a frame boundary, so a capture never disturbs a frame that is still being sent. An active-low sleep input turns the outputs off. It drops any word that is held or being shifted. The slot counter keeps running, so the framing lane comes back in phase at wake-up. The electrical drivers are modelled as single-ended bits with one output-enable.

Top module: `pix7_serializer`

## Requirements
- R1: While `rst_n` is low, `lane_oe` is 0 and every lane output is 0.
- R2: Data lane L, in slot S (S = 0 is the first slot after a frame boundary), carries bit 7*L+S of the loaded word. Lane 0 carries bits 0..6, lane 1 carries bits 7..13 and lane 2 carries bits 14..20, lowest bit first.
- R3: While enabled, the framing lane sends the slot pattern 1,1,0,0,0,1,1 for slots 0..6, giving one rising edge per pixel period, at slot 5.
- R4: With `edge_rise_sel` = 1, the word captured is the one present at the bit-clock edge where `pix_clk` is first sampled high after being sampled low.
- R5: With `edge_rise_sel` = 0, the word captured is the one present at the bit-clock edge where `pix_clk` is first sampled low after being sampled high.
- R6: The bit-clock edge that detects a rising pixel edge puts the slot counter at slot 1. The frame load happens at the edge that ends slot 6. The word captured in one pixel period is therefore sent in the next period, slot 0 following the sixth bit-clock edge after the rising pixel edge.
- R7: A capture during a frame in progress does not change that frame. The new word appears only from the next frame boundary.
- R8: A bit-clock edge that samples `sleep_n` low forces `lane_oe` to 0 and all lane outputs to 0 from that edge on, until an edge samples it high again.
- R9: Each edge that samples `sleep_n` low clears the held word and the shift registers, and any frame load or capture at that edge is dropped. The slot counter keeps running, so after wake-up the framing lane is in phase at once. The data lanes send 0 until a word captured while awake has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled as a level on `clk_bit` |
| edge_rise_sel | input | 1 | Static strap: 1 captures on the rising pixel edge, 0 on the falling edge |
| sleep_n | input | 1 | Active-low sleep; low turns the outputs off and clears the data path |
| pix_word | input | 21 | Pixel word: colour bits and timing bits |
| lane_data | output | 3 | Serial data lanes, one bit per slot |
| lane_frame | output | 1 | Framing lane, pattern 1100011 per pixel period |
| lane_oe | output | 1 | Output enable for all four lanes |

## Verification
The case that needs care is sleep entry on the same bit-clock edge as a frame load. The bench drives `sleep_n` low exactly at the sixth phase of a pixel period, where the shadow word would move into the shift registers. It then checks two things. The lanes must go quiet from that edge. After a wake-up placed just after a rising pixel edge, the first frame must carry all-zero data while the framing lane is already in phase. The second overlap is a falling-edge capture landing in the middle of a frame. Randomized words are driven that differ between the high and low phases of the pixel clock, and each frame must match the word captured one period earlier.

// File: rtl/pix7_pkg.sv
package pix7_pkg;

   typedef enum logic {
      CAP_FALL = 1'b0,
      CAP_RISE = 1'b1
   } cap_edge_e;

   // Framing lane level for one slot: a high run of LEAD slots at the start
   // of the frame and TAIL slots at its end, low in between.
   function automatic logic frame_level(input int unsigned slot,
                                        input int unsigned slots);
      int unsigned tail;
      int unsigned lead;
      tail = (slots + 1) / 4;
      lead = (slots + 1) / 2 - tail;
      return (slot < lead) || (slot >= slots - tail);
   endfunction

endpackage

// File: rtl/pix7_capture.sv
module pix7_capture
   import pix7_pkg::*;
#(
   parameter int unsigned WORD_W = 21
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              pix_clk,
   input  logic              edge_rise_sel,
   input  logic              sleep_n,
   input  logic [WORD_W-1:0] pix_word,
   output logic              rise_det,
   output logic [WORD_W-1:0] held_word
);

   logic      pclk_q;
   logic      fall_det;
   logic      strobe;
   cap_edge_e cap_edge;

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n) pclk_q <= 1'b0;
      else        pclk_q <= pix_clk;
   end

   assign rise_det = pix_clk & ~pclk_q;
   assign fall_det = ~pix_clk & pclk_q;
   assign cap_edge = cap_edge_e'(edge_rise_sel);

   always_comb begin
      unique case (cap_edge)
         CAP_RISE: strobe = rise_det;
         default:  strobe = fall_det;
      endcase
   end

   // Shadow register: holds the captured word until the frame boundary.
   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)       held_word <= '0;
      else if (!sleep_n) held_word <= '0;
      else if (strobe)  held_word <= pix_word;
   end

endmodule

// File: rtl/pix7_slot_timer.sv
module pix7_slot_timer
   import pix7_pkg::*;
#(
   parameter int unsigned SLOTS = 7,
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              resync,
   output logic [SLOT_W-1:0] slot,
   output logic              load,
   output logic              frame_bit
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
   localparam logic [SLOT_W-1:0] SYNC_SLOT = SLOT_W'(1);

   logic [SLOTS-1:0] pattern;

   for (genvar gs = 0; gs < SLOTS; gs++) begin : g_pat
      assign pattern[gs] = frame_level(gs, SLOTS);
   end

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)                slot <= '0;
      else if (resync)           slot <= SYNC_SLOT;
      else if (slot == LAST_SLOT) slot <= '0;
      else                       slot <= slot + SLOT_W'(1);
   end

   assign load      = (slot == LAST_SLOT);
   assign frame_bit = pattern[slot];

endmodule

// File: rtl/pix7_lane_shift.sv
module pix7_lane_shift #(
   parameter int unsigned SLOTS = 7
) (
   input  logic             clk_bit,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [SLOTS-1:0] par_in,
   output logic             ser_out
);

   logic [SLOTS-1:0] sr;

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (clear) sr <= '0;
      else if (load)  sr <= par_in;
      else            sr <= {1'b0, sr[SLOTS-1:1]};
   end

   assign ser_out = sr[0];

endmodule

// File: rtl/pix7_serializer.sv
module pix7_serializer #(
   parameter int unsigned LANES  = 3,
   parameter int unsigned SLOTS  = 7,
   parameter int unsigned WORD_W = 21,
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              pix_clk,
   input  logic              edge_rise_sel,
   input  logic              sleep_n,
   input  logic [WORD_W-1:0] pix_word,
   output logic [LANES-1:0]  lane_data,
   output logic              lane_frame,
   output logic              lane_oe
);

   if (WORD_W != LANES * SLOTS) begin : g_bad_width
      $error("pix7_serializer: WORD_W must equal LANES*SLOTS");
   end
   if (SLOTS < 5) begin : g_bad_slots
      $error("pix7_serializer: SLOTS must be at least 5");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("pix7_serializer: LANES must be at least 1");
   end

   logic              awake_q;
   logic              rise_det;
   logic              load;
   logic              frame_bit;
   logic [SLOT_W-1:0] slot_q;
   logic [WORD_W-1:0] held_word;
   logic [LANES-1:0]  ser_bits;

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n) awake_q <= 1'b0;
      else        awake_q <= sleep_n;
   end

   pix7_capture #(.WORD_W(WORD_W)) u_cap (
      .clk_bit       (clk_bit),
      .rst_n         (rst_n),
      .pix_clk       (pix_clk),
      .edge_rise_sel (edge_rise_sel),
      .sleep_n       (sleep_n),
      .pix_word      (pix_word),
      .rise_det      (rise_det),
      .held_word     (held_word)
   );

   pix7_slot_timer #(.SLOTS(SLOTS)) u_tmr (
      .clk_bit   (clk_bit),
      .rst_n     (rst_n),
      .resync    (rise_det),
      .slot      (slot_q),
      .load      (load),
      .frame_bit (frame_bit)
   );

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      pix7_lane_shift #(.SLOTS(SLOTS)) u_sh (
         .clk_bit (clk_bit),
         .rst_n   (rst_n),
         .clear   (~sleep_n),
         .load    (load),
         .par_in  (held_word[gl*SLOTS +: SLOTS]),
         .ser_out (ser_bits[gl])
      );
   end

   assign lane_oe    = awake_q;
   assign lane_data  = awake_q ? ser_bits : '0;
   assign lane_frame = awake_q & frame_bit;

endmodule

// File: rtl/pix7_serializer_chk.sv
module pix7_serializer_chk #(
   parameter int unsigned LANES  = 3,
   parameter int unsigned SLOTS  = 7,
   parameter int unsigned SLOT_W = 3
) (
   input logic              clk_bit,
   input logic              rst_n,
   input logic              sleep_n,
   input logic [LANES-1:0]  lane_data,
   input logic              lane_frame,
   input logic              lane_oe,
   input logic [SLOT_W-1:0] slot
);

   localparam int unsigned TAIL = (SLOTS + 1) / 4;
   localparam int unsigned LEAD = (SLOTS + 1) / 2 - TAIL;
   localparam logic [SLOT_W-1:0] RISE_SLOT = SLOT_W'(SLOTS - TAIL);
   localparam logic [SLOT_W-1:0] FALL_SLOT = SLOT_W'(LEAD);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   always @(posedge clk_bit) begin
      if (!rst_n) AST_RESET_QUIET: assert (!lane_oe && lane_data == '0 && !lane_frame); // R1
   end

   AST_SLEEP_OFF: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !sleep_n |=> !lane_oe); // R8
   AST_OFF_QUIET: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !lane_oe |-> (lane_data == '0 && !lane_frame)); // R8
   AST_WAKE_EMPTY: assert property (@(posedge clk_bit) disable iff (!rst_n)
      $rose(lane_oe) |-> lane_data == '0); // R9
   AST_FRAME_RISE: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (lane_oe && $past(lane_oe) && $rose(lane_frame)) |-> (slot == RISE_SLOT || slot == SLOT_W'(1))); // R3
   AST_FRAME_FALL: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (lane_oe && $past(lane_oe) && $fell(lane_frame)) |-> slot == FALL_SLOT); // R3
   AST_SLOT_RANGE: assert property (@(posedge clk_bit) disable iff (!rst_n)
      slot <= LAST_SLOT); // R6
   AST_SLOT_WRAP: assert property (@(posedge clk_bit) disable iff (!rst_n)
      slot == LAST_SLOT |=> (slot == '0 || slot == SLOT_W'(1))); // R6

endmodule

bind pix7_serializer pix7_serializer_chk #(
   .LANES  (LANES),
   .SLOTS  (SLOTS),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk_bit    (clk_bit),
   .rst_n      (rst_n),
   .sleep_n    (sleep_n),
   .lane_data  (lane_data),
   .lane_frame (lane_frame),
   .lane_oe    (lane_oe),
   .slot       (slot_q)
);

// File: tb/sim_pix7_serializer.sv
module sim_pix7_serializer;

   logic        clk_bit = 1'b0;
   logic        rst_n;
   logic        pix_clk;
   logic        edge_rise_sel;
   logic        sleep_n;
   logic [20:0] pix_word;
   logic [2:0]  lane_data;
   logic        lane_frame;
   logic        lane_oe;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk_bit = ~clk_bit;

   pix7_serializer u0 (
      .clk_bit       (clk_bit),
      .rst_n         (rst_n),
      .pix_clk       (pix_clk),
      .edge_rise_sel (edge_rise_sel),
      .sleep_n       (sleep_n),
      .pix_word      (pix_word),
      .lane_data     (lane_data),
      .lane_frame    (lane_frame),
      .lane_oe       (lane_oe)
   );

   // Framing lane level per slot, from R3: 1,1,0,0,0,1,1
   function automatic logic frame_ref(input int s);
      return (s <= 1) || (s >= 5);
   endfunction

   // Expected {oe, frame, lane2, lane1, lane0} in slot s (R2, R3, R8)
   function automatic logic [4:0] expect_vec(input logic [20:0] w, input int s, input logic oe);
      if (!oe) return 5'b0;
      return {1'b1, frame_ref(s), w[14 + s], w[7 + s], w[s]};
   endfunction

   // One pixel period: sample each slot, then drive the next bit-clock phase.
   task automatic run_pixel(input logic [20:0] rw, input logic [20:0] fw,
                            input logic [6:0] sl, input logic [20:0] ew,
                            input logic [6:0] eoe, input bit chk, input string tag);
      for (int ph = 0; ph < 7; ph++) begin
         @(negedge clk_bit);
         if (chk) begin
            logic [4:0] got;
            logic [4:0] exp;
            got = {lane_oe, lane_frame, lane_data};
            exp = expect_vec(ew, ph, eoe[ph]);
            n_vec++;
            if (got !== exp) begin
               n_bad++;
               $display("FAIL %s slot %0d got %b expected %b", tag, ph, got, exp);
            end
         end
         pix_clk  = (ph < 4);
         pix_word = (ph < 4) ? rw : fw;
         sleep_n  = sl[ph];
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_bit);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [20:0] prev;
      logic [20:0] rw;
      logic [20:0] fw;
      void'($urandom(32'h00C0FFEE));
      rst_n         = 1'b0;
      pix_clk       = 1'b0;
      edge_rise_sel = 1'b1;
      sleep_n       = 1'b1;
      pix_word      = '0;

      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk_bit);
         n_vec++;
         if ({lane_oe, lane_frame, lane_data} !== 5'b0) begin
            n_bad++;
            $display("FAIL R1 got %b expected %b", {lane_oe, lane_frame, lane_data}, 5'b0);
         end
      end
      rst_n = 1'b1;

      // Lock-in pixel, no check
      rw = 21'($urandom());
      fw = 21'($urandom());
      run_pixel(rw, fw, 7'h7F, '0, 7'h7F, 1'b0, "lock");
      prev = rw;

      // Directed corner words, rising capture (R2, R4)
      run_pixel(21'h1FFFFF, 21'h000000, 7'h7F, prev, 7'h7F, 1'b1, "R2 R4");
      prev = 21'h1FFFFF;
      run_pixel(21'h0AAAAA, 21'h155555, 7'h7F, prev, 7'h7F, 1'b1, "R2 R4");
      prev = 21'h0AAAAA;
      run_pixel(21'h000001, 21'h1FFFFE, 7'h7F, prev, 7'h7F, 1'b1, "R2 R4");
      prev = 21'h000001;
      run_pixel(21'h100000, 21'h0FFFFF, 7'h7F, prev, 7'h7F, 1'b1, "R2 R4");
      prev = 21'h100000;

      // Random rising-edge capture (R2, R3, R4, R6)
      for (int k = 0; k < 40; k++) begin
         rw = 21'($urandom());
         fw = ~rw;
         run_pixel(rw, fw, 7'h7F, prev, 7'h7F, 1'b1, "R4 R6");
         prev = rw;
      end

      // Falling-edge capture during a frame in progress (R5, R7)
      edge_rise_sel = 1'b0;
      for (int k = 0; k < 40; k++) begin
         rw = 21'($urandom());
         fw = 21'($urandom());
         run_pixel(rw, fw, 7'h7F, prev, 7'h7F, 1'b1, "R5 R7");
         prev = fw;
      end
      run_pixel(21'h000000, 21'h1FFFFF, 7'h7F, prev, 7'h7F, 1'b1, "R5");
      prev = 21'h1FFFFF;

      // Back to rising, then sleep entry on the load edge (R8, R9)
      edge_rise_sel = 1'b1;
      rw = 21'($urandom());
      run_pixel(rw, ~rw, 7'h7F, prev, 7'h7F, 1'b1, "R4");
      prev = rw;
      rw = 21'($urandom());
      run_pixel(rw, ~rw, 7'b0111111, prev, 7'h7F, 1'b1, "R8");
      run_pixel(21'h1FFFFF, 21'h1FFFFF, 7'b0000000, '0, 7'h00, 1'b1, "R8");
      run_pixel(21'h1FFFFF, 21'h1FFFFF, 7'b1111110, '0, 7'b1111100, 1'b1, "R9");
      rw = 21'($urandom());
      run_pixel(rw, ~rw, 7'h7F, '0, 7'h7F, 1'b1, "R9");
      prev = rw;
      for (int k = 0; k < 6; k++) begin
         rw = 21'($urandom());
         run_pixel(rw, ~rw, 7'h7F, prev, 7'h7F, 1'b1, "R9");
         prev = rw;
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule